// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block takes one DMA transfer at a time from a client: a start byte address, a byte length and a direction. It turns that transfer into a chain of memory requests, each kept inside one cache line. The first request runs from the start address, which may be unaligned, to the end of its line or to the end of the transfer. Every later request starts on a line boundary and covers a whole line, except a shorter last request. Only one memory request is outstanding at a time. The next request is sent only after the previous one has been answered, by a data response for a read or an acknowledge for a write.

The client sends write data and receives read data as byte streams with valid/ready handshakes. For a write, the block gathers the bytes of each chunk into a line-wide buffer at their lanes in the line, then sends the request. For a read, it stores the returned line and streams the chunk's bytes back out in address order. When the last chunk is finished, the block pulses completion with the transfer's ID and is ready for the next transfer. A zero-length transfer completes without any memory request.

Top module: `dma_line_seq`

## Requirements
- R1: `cmd_ready` is high only while no transfer is active. After reset, `cmd_ready`=1, `cmd_id`=0 and every other valid, ready and flag output is 0. A `cmd_valid` held while busy starts nothing.
- R2: `cmd_type` 0 means load (read) and 1 means store (write). Codes 2 and 3 complete a handshake but start nothing. They raise `cmd_err` for exactly the cycle after that handshake and leave `cmd_id` unchanged.
- R3: `cmd_id` shows the ID the next legal transfer receives. It is 0 after reset, rises by 1 (wrapping) on each legal accept, and `done_id` returns the value shown at that transfer's accept.
- R4: The first memory request has address = start address and length = min(len, L − (start mod L)), where L is the line size in bytes.
- R5: Every later request starts at start address + bytes already completed, is line aligned (address mod L = 0) and has length min(remaining bytes, L). The request lengths add up to the transfer length.
- R6: At most one memory request is outstanding. `mem_req_valid` does not rise again until the current request's response has been taken (`mem_rsp_valid` while `mem_rsp_ready`).
- R7: On a write, the client bytes are taken in order. On each request, byte lane (addr mod L)+k of `mem_req_data` (lane j = bits 8j+7:8j) holds the chunk's k-th byte, and all other lanes are 0. The request is sent only after all bytes of its chunk have been taken.
- R8: On a read, the returned line is stored, and lanes (addr mod L) up to (addr mod L)+len−1 are sent on `rd_data` in order. The first chunk starts at the start offset and every later chunk starts at lane 0.
- R9: `done_valid` is high for exactly one cycle. For a write it follows the last acknowledge, and for a read it follows the last delivered byte. `cmd_ready` is high in the cycle after it.
- R10: A transfer of length 0 raises `done_valid` in the cycle after its accept and sends no memory request.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, length and data hold steady.
- R12: `mem_req_line` is the request address with its low log2(L) bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Transfer command offered |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_type | input | 2 | 0 load, 1 store, others illegal |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Length in bytes |
| cmd_id | output | ID_W | ID the next legal transfer receives |
| cmd_err | output | 1 | One-cycle flag after an illegal command |
| wr_valid | input | 1 | Client write byte valid |
| wr_ready | output | 1 | Block takes a write byte |
| wr_data | input | 8 | Client write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Client takes the read byte |
| rd_data | output | 8 | Read byte |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory side takes the request |
| mem_req_write | output | 1 | 1 for store, 0 for load |
| mem_req_addr | output | ADDR_W | Byte address of the chunk |
| mem_req_line | output | ADDR_W | Line address of the chunk |
| mem_req_len | output | log2(L)+1 | Chunk length in bytes |
| mem_req_data | output | 8·L | Write data placed at its byte lanes |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_ready | output | 1 | Block is waiting for a response |
| mem_rsp_data | input | 8·L | Returned line for reads |
| done_valid | output | 1 | Transfer complete pulse |
| done_id | output | ID_W | ID of the completed transfer |

## Verification
A command accepted at one clock edge shows up one edge later: `cmd_ready` drops, `cmd_err` or `cmd_id` changes, and a request, a write-byte request or (for length 0) `done_valid` appears. A response taken at an edge produces the next read byte, write-byte request or completion pulse at the following edge. So the bench drives inputs on the falling edge and samples every output on the next falling edge, judging each handshake by the values present just before the rising edge that completes it. Request fields are checked at the moment the bench grants the request, against lengths and lanes worked out arithmetically from the address, the length and the bytes already granted.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ISSUE,
    ST_WAIT,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
endpackage

// File: rtl/dma_chunk_plan.sv
// Works out the address, in-line offset and length of the chunk that
// begins after done_len bytes of a transfer.
module dma_chunk_plan #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [LEN_W-1:0]  done_len,
  output logic [ADDR_W-1:0] chunk_addr,
  output logic [ADDR_W-1:0] chunk_line,
  output logic [OFF_W-1:0]  chunk_off,
  output logic [CLEN_W-1:0] chunk_len
);
  logic [LEN_W-1:0]  remain;
  logic [CLEN_W-1:0] room;

  always_comb begin
    chunk_addr = base_addr + ADDR_W'(done_len);
    chunk_off  = chunk_addr[OFF_W-1:0];
    chunk_line = {chunk_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    remain     = total_len - done_len;
    room       = CLEN_W'(LINE_BYTES) - {1'b0, chunk_off};
    if (remain < LEN_W'(room)) chunk_len = remain[CLEN_W-1:0];
    else                       chunk_len = room;
  end
endmodule

// File: rtl/dma_line_buf.sv
// Line-wide byte buffer: clear, single-byte write, whole-line load, byte read.
module dma_line_buf #(
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic              load_en,
  input  logic [LINE_W-1:0] load_line,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [7:0]        rd_byte,
  output logic [LINE_W-1:0] line_out
);
  logic [7:0] lane_q [LINE_BYTES];

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    logic [7:0] lane_n;
    logic       lane_en;

    always_comb begin
      lane_en = load_en || clr || (wr_en && (wr_idx == OFF_W'(g)));
      if (load_en)  lane_n = load_line[g*8 +: 8];
      else if (clr) lane_n = 8'h00;
      else          lane_n = wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q[g] <= 8'h00;
      else if (lane_en) lane_q[g] <= lane_n;
    end

    assign line_out[g*8 +: 8] = lane_q[g];
  end

  assign rd_byte = lane_q[rd_idx];
endmodule

// File: rtl/dma_id_gen.sv
// Transfer ID counter: shows the next ID, steps when one is taken.
module dma_id_gen #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  output logic [ID_W-1:0] next_id
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    id_q <= '0;
    else if (take) id_q <= id_q + 1'b1;
  end

  assign next_id = id_q;
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [1:0]                    cmd_type,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [LEN_W-1:0]              cmd_len,
  output logic [ID_W-1:0]               cmd_id,
  output logic                          cmd_err,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [7:0]                    wr_data,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output logic [7:0]                    rd_data,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic                          mem_req_write,
  output logic [ADDR_W-1:0]             mem_req_addr,
  output logic [ADDR_W-1:0]             mem_req_line,
  output logic [$clog2(LINE_BYTES):0]   mem_req_len,
  output logic [8*LINE_BYTES-1:0]       mem_req_data,
  input  logic                          mem_rsp_valid,
  output logic                          mem_rsp_ready,
  input  logic [8*LINE_BYTES-1:0]       mem_rsp_data,
  output logic                          done_valid,
  output logic [ID_W-1:0]               done_id
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int CLEN_W = OFF_W + 1;
  localparam int LINE_W = 8 * LINE_BYTES;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // state
  seq_state_e        state_q, state_n;
  logic [ADDR_W-1:0] start_q, start_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic              write_q, write_n;
  logic [ID_W-1:0]   act_id_q, act_id_n;
  logic [LEN_W-1:0]  issued_q, issued_n;
  logic [LEN_W-1:0]  compl_q, compl_n;
  logic [ADDR_W-1:0] caddr_q;
  logic [ADDR_W-1:0] cline_q;
  logic [OFF_W-1:0]  coff_q;
  logic [CLEN_W-1:0] clen_q;
  logic [CLEN_W-1:0] bidx_q, bidx_n;
  logic              err_q, err_n;

  // helpers
  logic              is_idle, cmd_take, cmd_legal, start_xfer, new_chunk;
  logic              buf_clr, buf_wr, buf_load;
  logic [ADDR_W-1:0] plan_base, plan_addr, plan_line;
  logic [LEN_W-1:0]  plan_total, plan_done;
  logic [OFF_W-1:0]  plan_off;
  logic [CLEN_W-1:0] plan_len;
  logic [OFF_W-1:0]  lane_idx;
  logic [LINE_W-1:0] buf_line;
  logic [ID_W-1:0]   next_id;
  logic              last_byte;

  assign is_idle    = (state_q == ST_IDLE);
  assign cmd_take   = cmd_valid && is_idle;
  assign cmd_legal  = (cmd_type == OP_LOAD) || (cmd_type == OP_STORE);
  assign start_xfer = cmd_take && cmd_legal;
  assign lane_idx   = coff_q + bidx_q[OFF_W-1:0];
  assign last_byte  = (bidx_q == clen_q - 1'b1);

  // when a new chunk begins, bytes completed equals bytes issued
  assign plan_base  = is_idle ? cmd_addr : start_q;
  assign plan_total = is_idle ? cmd_len  : len_q;
  assign plan_done  = is_idle ? '0       : issued_q;

  dma_chunk_plan #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_plan (
    .base_addr (plan_base),
    .total_len (plan_total),
    .done_len  (plan_done),
    .chunk_addr(plan_addr),
    .chunk_line(plan_line),
    .chunk_off (plan_off),
    .chunk_len (plan_len)
  );

  dma_line_buf #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr      (buf_clr),
    .wr_en    (buf_wr),
    .wr_idx   (lane_idx),
    .wr_byte  (wr_data),
    .load_en  (buf_load),
    .load_line(mem_rsp_data),
    .rd_idx   (lane_idx),
    .rd_byte  (rd_data),
    .line_out (buf_line)
  );

  dma_id_gen #(.ID_W(ID_W)) u_id (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .take   (start_xfer),
    .next_id(next_id)
  );

  // next-state logic
  always_comb begin
    state_n   = state_q;
    start_n   = start_q;
    len_n     = len_q;
    write_n   = write_q;
    act_id_n  = act_id_q;
    issued_n  = issued_q;
    compl_n   = compl_q;
    bidx_n    = bidx_q;
    err_n     = cmd_take && !cmd_legal;
    new_chunk = 1'b0;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    buf_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_xfer) begin
          start_n  = cmd_addr;
          len_n    = cmd_len;
          write_n  = (cmd_type == OP_STORE);
          act_id_n = next_id;
          issued_n = '0;
          compl_n  = '0;
          bidx_n   = '0;
          if (cmd_len == '0) begin
            state_n = ST_DONE;
          end else begin
            new_chunk = 1'b1;
            if (cmd_type == OP_STORE) begin
              buf_clr = 1'b1;
              state_n = ST_FILL;
            end else begin
              state_n = ST_ISSUE;
            end
          end
        end
      end
      ST_FILL: begin
        if (wr_valid) begin
          buf_wr = 1'b1;
          if (last_byte) begin
            bidx_n  = '0;
            state_n = ST_ISSUE;
          end else begin
            bidx_n = bidx_q + 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) begin
          issued_n = issued_q + LEN_W'(clen_q);
          state_n  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          compl_n = issued_q;
          if (write_q) begin
            if (issued_q == len_q) begin
              state_n = ST_DONE;
            end else begin
              new_chunk = 1'b1;
              buf_clr   = 1'b1;
              state_n   = ST_FILL;
            end
          end else begin
            buf_load = 1'b1;
            bidx_n   = '0;
            state_n  = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (rd_ready) begin
          if (last_byte) begin
            bidx_n = '0;
            if (compl_q == len_q) begin
              state_n = ST_DONE;
            end else begin
              new_chunk = 1'b1;
              state_n   = ST_ISSUE;
            end
          end else begin
            bidx_n = bidx_q + 1'b1;
          end
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q  <= ST_IDLE;
      start_q  <= '0;
      len_q    <= '0;
      write_q  <= 1'b0;
      act_id_q <= '0;
      issued_q <= '0;
      compl_q  <= '0;
      bidx_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      start_q  <= start_n;
      len_q    <= len_n;
      write_q  <= write_n;
      act_id_q <= act_id_n;
      issued_q <= issued_n;
      compl_q  <= compl_n;
      bidx_q   <= bidx_n;
      err_q    <= err_n;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      caddr_q <= '0;
      cline_q <= '0;
      coff_q  <= '0;
      clen_q  <= '0;
    end else if (new_chunk) begin
      caddr_q <= plan_addr;
      cline_q <= plan_line;
      coff_q  <= plan_off;
      clen_q  <= plan_len;
    end
  end

  // outputs
  assign cmd_ready     = is_idle;
  assign cmd_id        = next_id;
  assign cmd_err       = err_q;
  assign wr_ready      = (state_q == ST_FILL);
  assign rd_valid      = (state_q == ST_DRAIN);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_write = write_q;
  assign mem_req_addr  = caddr_q;
  assign mem_req_line  = cline_q;
  assign mem_req_len   = clen_q;
  assign mem_req_data  = buf_line;
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign done_valid    = (state_q == ST_DONE);
  assign done_id       = act_id_q;
endmodule

// File: rtl/dma_line_seq_chk.sv
module dma_line_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = 8 * LINE_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_type,
  input logic [ID_W-1:0]   cmd_id,
  input logic              cmd_err,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [OFF_W:0]    mem_req_len,
  input logic [LINE_W-1:0] mem_req_data,
  input logic              mem_rsp_ready,
  input logic              done_valid
);
  // R1
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready || rd_valid || mem_req_valid || mem_rsp_ready) |-> !cmd_ready);

  // R6
  single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, wr_ready, rd_valid, mem_req_valid, mem_rsp_ready, done_valid}));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len) && $stable(mem_req_data)));

  // R4
  chunk_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |->
      ((mem_req_len != '0) && (int'(mem_req_addr[OFF_W-1:0]) + int'(mem_req_len) <= LINE_BYTES)));

  // R2
  err_follows_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_ready && (cmd_type != OP_LOAD) && (cmd_type != OP_STORE)));

  // R3
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && ((cmd_type == OP_LOAD) || (cmd_type == OP_STORE))) |=>
      (cmd_id == $past(cmd_id) + 1'b1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && cmd_ready));
endmodule

bind dma_line_seq dma_line_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ID_W(ID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_type     (cmd_type),
  .cmd_id       (cmd_id),
  .cmd_err      (cmd_err),
  .wr_ready     (wr_ready),
  .rd_valid     (rd_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_req_len  (mem_req_len),
  .mem_req_data (mem_req_data),
  .mem_rsp_ready(mem_rsp_ready),
  .done_valid   (done_valid)
);

// File: tb/sim_dma_line_seq.sv
module sim_dma_line_seq;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int L  = 8;
  localparam int IW = 8;
  localparam int OW = $clog2(L);

  logic            clk;
  logic            rst_n;
  logic            cmd_valid, cmd_ready, cmd_err;
  logic [1:0]      cmd_type;
  logic [AW-1:0]   cmd_addr;
  logic [LW-1:0]   cmd_len;
  logic [IW-1:0]   cmd_id;
  logic            wr_valid, wr_ready;
  logic [7:0]      wr_data;
  logic            rd_valid, rd_ready;
  logic [7:0]      rd_data;
  logic            mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0]   mem_req_addr, mem_req_line;
  logic [OW:0]     mem_req_len;
  logic [8*L-1:0]  mem_req_data;
  logic            mem_rsp_valid, mem_rsp_ready;
  logic [8*L-1:0]  mem_rsp_data;
  logic            done_valid;
  logic [IW-1:0]   done_id;

  int errors = 0;
  int checks = 0;
  logic [IW-1:0] exp_id;

  dma_line_seq #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(L), .ID_W(IW)) u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [7:0] wbyte(input logic [7:0] tag, input int k);
    return 8'(k * 13 + int'(tag));
  endfunction

  task automatic illegal_cmd(input logic [1:0] t);
    logic [IW-1:0] id0;
    @(negedge clk);
    id0 = cmd_id;
    cmd_valid = 1'b1; cmd_type = t; cmd_addr = 32'h40; cmd_len = 16'd5;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_err == 1'b1, "R2 err flag", cmd_err, 1);
    chk(cmd_ready == 1'b1, "R2 stays idle", cmd_ready, 1);
    chk(cmd_id == id0, "R2 id unchanged", cmd_id, id0);
    chk(!mem_req_valid && !wr_ready, "R2 nothing started", {mem_req_valid, wr_ready}, 0);
    @(negedge clk);
    chk(cmd_err == 1'b0, "R2 err one cycle", cmd_err, 0);
  endtask

  task automatic run_xfer(input logic [AW-1:0] a, input int n, input bit wr, input bit jam);
    int issued = 0;
    int got = 0;
    int nreq = 0;
    int dly = 0;
    int cyc = 0;
    bit pend = 0;
    bit stall;
    logic [AW-1:0] rline = '0;
    logic [7:0] tag;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", cmd_ready, 1);
    chk(cmd_id == exp_id, "R3 next id", cmd_id, exp_id);
    tag = exp_id;
    cmd_valid = 1'b1; cmd_type = wr ? 2'd1 : 2'd0; cmd_addr = a; cmd_len = LW'(n);
    @(negedge clk);
    if (jam) begin
      cmd_addr = 32'h777; cmd_len = 16'd3;
    end else begin
      cmd_valid = 1'b0;
    end
    chk(cmd_ready == 1'b0, "R1 busy after accept", cmd_ready, 0);
    exp_id = exp_id + 1'b1;
    forever begin
      cyc++;
      stall = ((cyc + int'(a[2:0])) % 4) == 3;
      // memory response
      if (pend && mem_rsp_ready && dly == 0) begin
        mem_rsp_valid = 1'b1;
        for (int j = 0; j < L; j++) mem_rsp_data[j*8 +: 8] = mem_byte(rline + AW'(j));
        pend = 0;
      end else begin
        mem_rsp_valid = 1'b0;
        if (pend && mem_rsp_ready) dly--;
      end
      // client write stream
      if (wr_ready && !stall) begin
        wr_valid = 1'b1; wr_data = wbyte(tag, got); got++;
      end else begin
        wr_valid = 1'b0;
      end
      // client read stream
      if (rd_valid && !stall) begin
        rd_ready = 1'b1;
        chk(rd_data == mem_byte(a + AW'(got)), "R8 read byte", rd_data, mem_byte(a + AW'(got)));
        got++;
      end else begin
        rd_ready = 1'b0;
      end
      // memory request
      if (mem_req_valid && !stall) begin
        int off, elen, room;
        logic [AW-1:0] eaddr;
        eaddr = a + AW'(issued);
        off   = int'(eaddr % L);
        room  = L - off;
        elen  = (n - issued < room) ? n - issued : room;
        chk(!pend, "R6 one outstanding", pend, 0);
        chk(mem_req_write == wr, "R7 direction", mem_req_write, wr);
        if (issued == 0) begin
          chk(mem_req_addr == eaddr, "R4 first addr", mem_req_addr, eaddr);
          chk(int'(mem_req_len) == elen, "R4 first len", mem_req_len, elen);
        end else begin
          chk(mem_req_addr == eaddr && off == 0, "R5 later addr aligned", mem_req_addr, eaddr);
          chk(int'(mem_req_len) == elen, "R5 later len", mem_req_len, elen);
        end
        chk(mem_req_line == (eaddr & ~AW'(L - 1)), "R12 line addr", mem_req_line, eaddr & ~AW'(L - 1));
        if (wr) begin
          chk(got == issued + elen, "R7 bytes gathered", got, issued + elen);
          for (int j = 0; j < L; j++) begin
            logic [7:0] ev;
            ev = (j >= off && j < off + elen) ? wbyte(tag, issued + j - off) : 8'h00;
            chk(mem_req_data[j*8 +: 8] == ev, "R7 lane data", mem_req_data[j*8 +: 8], ev);
          end
        end
        mem_req_ready = 1'b1;
        rline = mem_req_line;
        issued += int'(mem_req_len);
        nreq++;
        pend = 1;
        dly = cyc % 3;
      end else begin
        mem_req_ready = 1'b0;
      end
      if (done_valid) begin
        chk(done_id == tag, "R3 done id", done_id, tag);
        chk(issued == n, "R5 lengths add up", issued, n);
        chk(got == n, "R9 all bytes moved before done", got, n);
        if (n == 0) chk(nreq == 0 && cyc == 1, "R10 zero length", nreq, 0);
        cmd_valid = 1'b0;
        wr_valid = 1'b0; rd_ready = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        @(negedge clk);
        chk(done_valid == 1'b0 && cmd_ready == 1'b1, "R9 pulse then idle", {done_valid, cmd_ready}, 1);
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_type = 2'd0; cmd_addr = '0; cmd_len = '0;
    wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    exp_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    chk(cmd_id == '0, "R1 reset id", cmd_id, 0);
    chk({cmd_err, wr_ready, rd_valid, mem_req_valid, mem_rsp_ready, done_valid} == '0,
        "R1 reset flags", {cmd_err, wr_ready, rd_valid, mem_req_valid, mem_rsp_ready, done_valid}, 0);
    illegal_cmd(2'd2);
    illegal_cmd(2'd3);
    for (int wr = 0; wr < 2; wr++)
      for (int s = 0; s < 20; s++)
        for (int n = 0; n < 20; n++)
          run_xfer(32'h1000 + AW'(s), n, wr[0], ((s + n) % 5) == 0);
    run_xfer(32'h2003, 300, 1'b0, 1'b0);
    run_xfer(32'h3005, 300, 1'b1, 1'b1);
    illegal_cmd(2'd3);
    run_xfer(32'h0, 8, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule